// File: doc/BRIEF.md
# Modulo and Bit-Reversed Address Generator

This block computes data-memory addresses for a 16-bit, byte-addressed data space (64 Kbytes, or 32K 16-bit words). On each request it takes a pointer and a signed byte step. It returns two values one clock later. The first is the address to access, which is the pointer itself. The second is the updated pointer that the caller writes back.

The update can run in three ways:
- Linear: plain two's-complement addition.
- Circular: the pointer wraps inside a buffer bounded by a programmable first and last byte address. This works for both ascending and descending traversal, so loops over circular buffers need no bounds checks in software.
- Bit-reversed: the step is added with its carry running from the high bit of a 2^N-word field toward the low bit. Stepping by half the span then visits the entries of a radix-2 FFT buffer in reordered sequence.

Circular mode is meant for any access, not only signal-processing ones. When a mode's configuration disables it, the update falls back to linear arithmetic.

Top module: `agu_addr_gen`

## Requirements
- R1: After reset `valid_o`, `addr_o` and `next_o` are all zero. A request sampled on a rising edge raises `valid_o` and updates both addresses at that same edge, so results appear with one cycle of latency.
- R2: `addr_o` equals the requested pointer. When `word_i` is 1, bit 0 of `addr_o` is forced to 0. When `word_i` is 0, all pointer bits pass through unchanged.
- R3: With `mode_i` = 0 (linear) or `mode_i` = 3 (spare), `next_o` = (`ptr_i` + `step_i`) mod 2^16, where `step_i` is a signed byte step.
- R4: With `mode_i` = 1 (circular) and `buf_start_i` <= `buf_end_i`, a sum ptr+step above `buf_end_i` wraps to sum − L, where L = `buf_end_i` − `buf_start_i` + 1. This includes sums that pass 0xFFFF.
- R5: In circular mode, a sum below `buf_start_i` wraps to sum + L. This includes sums that fall below 0.
- R6: In circular mode, a sum within [`buf_start_i`, `buf_end_i`] is returned unchanged. A pointer inside the buffer, moved by a step whose magnitude is below L, always stays inside the buffer.
- R7: In circular mode with `buf_end_i` < `buf_start_i`, the update is linear as in R3.
- R8: With `mode_i` = 2 (bit-reversed) and `rev_span_i` = N with 1 <= N <= 15, the step is added into byte-address bits [N:1]. The carry propagates from bit N down toward bit 1 and is discarded past bit 1. Bits above N and bit 0 of `next_o` equal those of `ptr_i`.
- R9: In bit-reversed mode with `rev_span_i` = 0, the update is linear as in R3.
- R10: In a cycle with `req_i` low, `valid_o` drops at the next edge while `addr_o` and `next_o` hold their values, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Address request this cycle |
| mode_i | input | 2 | 0 linear, 1 circular, 2 bit-reversed, 3 linear |
| word_i | input | 1 | 1 for a 16-bit access (address bit 0 cleared) |
| ptr_i | input | 16 | Current pointer, byte address |
| step_i | input | 16 | Signed step in bytes |
| buf_start_i | input | 16 | First byte address of circular buffer |
| buf_end_i | input | 16 | Last byte address of circular buffer |
| rev_span_i | input | 4 | Bit-reversed span exponent N (2^N words) |
| valid_o | output | 1 | Result valid |
| addr_o | output | 16 | Access address |
| next_o | output | 16 | Updated pointer |

## Verification
The bench builds the block with its default parameters: a 16-bit address and a 4-bit span exponent. With these values the top of the address space can be reached, so circular wraps whose raw sum passes 0xFFFF or drops below zero are exercised. The widest bit-reversed span, N = 15, is also reachable; there a carry runs across every bit from 15 down to 1. A full 16-point bit-reversed walk is fed back through the pointer and compared against a reference that reverses the field, adds, and reverses back.

// File: rtl/agu_pkg.sv
package agu_pkg;

    typedef enum logic [1:0] {
        SM_LINEAR  = 2'd0,
        SM_CIRC    = 2'd1,
        SM_REVERSE = 2'd2,
        SM_SPARE   = 2'd3
    } step_mode_e;

endpackage

// File: rtl/agu_circ_step.sv
module agu_circ_step #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] ptr_i,
    input  logic [ADDR_W-1:0] step_i,
    input  logic [ADDR_W-1:0] lo_i,
    input  logic [ADDR_W-1:0] hi_i,
    output logic              cfg_ok_o,
    output logic [ADDR_W-1:0] nxt_o
);
    localparam int SW = ADDR_W + 2;

    logic signed [SW-1:0] sum_s;
    logic signed [SW-1:0] lo_s;
    logic signed [SW-1:0] hi_s;
    logic signed [SW-1:0] len_s;
    logic signed [SW-1:0] res_s;

    always_comb begin
        sum_s = $signed({2'b00, ptr_i}) + $signed({{2{step_i[ADDR_W-1]}}, step_i});
        lo_s  = $signed({2'b00, lo_i});
        hi_s  = $signed({2'b00, hi_i});
        len_s = hi_s - lo_s + $signed({{(SW-1){1'b0}}, 1'b1});
        if (sum_s > hi_s) begin
            res_s = sum_s - len_s;
        end else if (sum_s < lo_s) begin
            res_s = sum_s + len_s;
        end else begin
            res_s = sum_s;
        end
        cfg_ok_o = (hi_i >= lo_i);
        nxt_o    = res_s[ADDR_W-1:0];
    end

endmodule

// File: rtl/agu_revcarry_step.sv
module agu_revcarry_step #(
    parameter int ADDR_W = 16,
    parameter int SPAN_W = 4
) (
    input  logic [ADDR_W-1:0] ptr_i,
    input  logic [ADDR_W-1:0] step_i,
    input  logic [SPAN_W-1:0] span_i,
    output logic [ADDR_W-1:0] nxt_o
);
    logic cy;

    always_comb begin
        cy    = 1'b0;
        nxt_o = ptr_i;
        for (int i = ADDR_W - 1; i >= 1; i--) begin
            if (i <= int'(span_i)) begin
                nxt_o[i] = ptr_i[i] ^ step_i[i] ^ cy;
                cy       = (ptr_i[i] & step_i[i]) | (cy & (ptr_i[i] ^ step_i[i]));
            end
        end
    end

endmodule

// File: rtl/agu_addr_gen.sv
module agu_addr_gen #(
    parameter int ADDR_W = 16,
    parameter int SPAN_W = $clog2(ADDR_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [1:0]        mode_i,
    input  logic              word_i,
    input  logic [ADDR_W-1:0] ptr_i,
    input  logic [ADDR_W-1:0] step_i,
    input  logic [ADDR_W-1:0] buf_start_i,
    input  logic [ADDR_W-1:0] buf_end_i,
    input  logic [SPAN_W-1:0] rev_span_i,
    output logic              valid_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [ADDR_W-1:0] next_o
);
    import agu_pkg::*;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] nxt;
    } agu_state_t;

    agu_state_t st_d, st_q;

    logic [ADDR_W-1:0] lin_sum;
    logic [ADDR_W-1:0] circ_sum;
    logic [ADDR_W-1:0] rev_sum;
    logic              circ_ok;
    logic [ADDR_W-1:0] rev_field;
    step_mode_e        mode_e;

    assign mode_e  = step_mode_e'(mode_i);
    assign lin_sum = ptr_i + step_i;

    agu_circ_step #(.ADDR_W(ADDR_W)) u_circ (
        .ptr_i    (ptr_i),
        .step_i   (step_i),
        .lo_i     (buf_start_i),
        .hi_i     (buf_end_i),
        .cfg_ok_o (circ_ok),
        .nxt_o    (circ_sum)
    );

    agu_revcarry_step #(.ADDR_W(ADDR_W), .SPAN_W(SPAN_W)) u_rev (
        .ptr_i  (ptr_i),
        .step_i (step_i),
        .span_i (rev_span_i),
        .nxt_o  (rev_sum)
    );

    // field of bits touched by a bit-reversed update, used by the checks below
    assign rev_field[0] = 1'b0;
    for (genvar g = 1; g < ADDR_W; g++) begin : g_field
        assign rev_field[g] = (g <= int'(rev_span_i));
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (req_i) begin
            st_d.valid = 1'b1;
            st_d.addr  = word_i ? {ptr_i[ADDR_W-1:1], 1'b0} : ptr_i;
            unique case (mode_e)
                SM_CIRC:    st_d.nxt = circ_ok ? circ_sum : lin_sum;
                SM_REVERSE: st_d.nxt = (rev_span_i != '0) ? rev_sum : lin_sum;
                default:    st_d.nxt = lin_sum;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.valid;
    assign addr_o  = st_q.addr;
    assign next_o  = st_q.nxt;

    // helpers for the containment check
    logic [ADDR_W:0] buf_len;
    logic [ADDR_W:0] step_mag;
    logic            ptr_in_buf;
    assign buf_len    = {1'b0, buf_end_i} - {1'b0, buf_start_i} + 1'b1;
    assign step_mag   = step_i[ADDR_W-1] ? ({1'b0, ~step_i} + 1'b1) : {1'b0, step_i};
    assign ptr_in_buf = (buf_start_i <= buf_end_i) && (ptr_i >= buf_start_i) && (ptr_i <= buf_end_i);

    AST_REQ_RAISES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> valid_o); // R1

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> (!valid_o && $stable(addr_o) && $stable(next_o))); // R10

    AST_WORD_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && word_i) |=> !addr_o[0]); // R2

    AST_ADDR_TRACKS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> (addr_o[ADDR_W-1:1] == $past(ptr_i[ADDR_W-1:1]))); // R2

    AST_LINEAR_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && (mode_i == 2'd0 || mode_i == 2'd3)) |=> (next_o == $past(ptr_i + step_i))); // R3

    AST_CIRC_STAYS_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && mode_i == 2'd1 && ptr_in_buf && step_mag < buf_len)
        |=> (next_o >= $past(buf_start_i) && next_o <= $past(buf_end_i))); // R6

    AST_REV_OUTSIDE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && mode_i == 2'd2 && rev_span_i != '0)
        |=> (((next_o ^ $past(ptr_i)) & ~$past(rev_field)) == '0)); // R8

endmodule

// File: tb/agu_addr_gen_test.sv
module agu_addr_gen_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [1:0]  mode_i = 2'd0;
    logic        word_i = 1'b0;
    logic [15:0] ptr_i = '0;
    logic [15:0] step_i = '0;
    logic [15:0] buf_start_i = '0;
    logic [15:0] buf_end_i = '0;
    logic [3:0]  rev_span_i = '0;
    logic        valid_o;
    logic [15:0] addr_o;
    logic [15:0] next_o;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    agu_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .mode_i(mode_i), .word_i(word_i),
        .ptr_i(ptr_i), .step_i(step_i), .buf_start_i(buf_start_i), .buf_end_i(buf_end_i),
        .rev_span_i(rev_span_i), .valid_o(valid_o), .addr_o(addr_o), .next_o(next_o)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int rev_bits(input int v, input int n);
        int r = 0;
        for (int i = 0; i < n; i++) r = (r << 1) | ((v >> i) & 1);
        return r;
    endfunction

    function automatic logic [15:0] ref_rev(input logic [15:0] p, input logic [15:0] s, input int n);
        int mask = (1 << n) - 1;
        int f = rev_bits((int'(p) >> 1) & mask, n);
        int t = rev_bits((int'(s) >> 1) & mask, n);
        int r = rev_bits((f + t) & mask, n);
        return 16'((int'(p) & ~(mask << 1)) | (r << 1));
    endfunction

    function automatic logic [15:0] ref_circ(input logic [15:0] p, input logic [15:0] s,
                                             input logic [15:0] lo, input logic [15:0] hi);
        int sum = int'(p) + int'($signed(s));
        int len = int'(hi) - int'(lo) + 1;
        if (sum > int'(hi)) sum -= len;
        else if (sum < int'(lo)) sum += len;
        return 16'(sum);
    endfunction

    task automatic issue(input logic [1:0] m, input logic w, input logic [15:0] p, input logic [15:0] s,
                         input logic [15:0] lo, input logic [15:0] hi, input logic [3:0] n);
        @(negedge clk);
        req_i = 1'b1; mode_i = m; word_i = w; ptr_i = p; step_i = s;
        buf_start_i = lo; buf_end_i = hi; rev_span_i = n;
        @(negedge clk);
        req_i = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 reset valid", {15'd0, valid_o}, 16'd0);
        chk("R1 reset addr", addr_o, 16'h0000);
        chk("R1 reset next", next_o, 16'h0000);
        issue(2'd0, 1'b0, 16'h0100, 16'h0002, 16'h0, 16'h0, 4'd0);
        chk("R1 valid after request", {15'd0, valid_o}, 16'd1);
    endtask

    task automatic t_linear;
        issue(2'd0, 1'b0, 16'h1234, 16'h0010, 16'h0, 16'h0, 4'd0);
        chk("R3 linear add", next_o, 16'h1244);
        issue(2'd0, 1'b0, 16'hFFFE, 16'h0004, 16'h0, 16'h0, 4'd0);
        chk("R3 linear wrap top", next_o, 16'h0002);
        issue(2'd3, 1'b0, 16'h0004, 16'hFFFA, 16'h0, 16'h0, 4'd0);
        chk("R3 spare mode negative step", next_o, 16'hFFFE);
    endtask

    task automatic t_word_addr;
        issue(2'd0, 1'b1, 16'h1235, 16'h0002, 16'h0, 16'h0, 4'd0);
        chk("R2 word clears bit0", addr_o, 16'h1234);
        issue(2'd0, 1'b0, 16'h1235, 16'h0002, 16'h0, 16'h0, 4'd0);
        chk("R2 byte keeps bit0", addr_o, 16'h1235);
    endtask

    task automatic t_idle_hold;
        issue(2'd0, 1'b0, 16'h0A00, 16'h0006, 16'h0, 16'h0, 4'd0);
        @(negedge clk);
        ptr_i = 16'h5555; step_i = 16'h0100; mode_i = 2'd1; word_i = 1'b1;
        @(negedge clk);
        chk("R10 idle valid low", {15'd0, valid_o}, 16'd0);
        chk("R10 idle addr held", addr_o, 16'h0A00);
        chk("R10 idle next held", next_o, 16'h0A06);
    endtask

    task automatic t_circ;
        issue(2'd1, 1'b0, 16'h101C, 16'h0006, 16'h1000, 16'h101F, 4'd0);
        chk("R4 ascending wrap", next_o, 16'h1002);
        issue(2'd1, 1'b0, 16'hFFFC, 16'h0008, 16'hFFE0, 16'hFFFF, 4'd0);
        chk("R4 wrap past top of space", next_o, 16'hFFE4);
        issue(2'd1, 1'b0, 16'h1002, 16'hFFFA, 16'h1000, 16'h101F, 4'd0);
        chk("R5 descending wrap", next_o, 16'h101C);
        issue(2'd1, 1'b0, 16'h0002, 16'hFFFC, 16'h0000, 16'h000F, 4'd0);
        chk("R5 wrap below zero", next_o, ref_circ(16'h0002, 16'hFFFC, 16'h0000, 16'h000F));
        issue(2'd1, 1'b0, 16'h1004, 16'h0004, 16'h1000, 16'h101F, 4'd0);
        chk("R6 inside no wrap", next_o, 16'h1008);
        issue(2'd1, 1'b0, 16'h101E, 16'h0001, 16'h1000, 16'h101F, 4'd0);
        chk("R6 land on last byte", next_o, 16'h101F);
        issue(2'd1, 1'b0, 16'h1FFE, 16'h0004, 16'h2000, 16'h1000, 4'd0);
        chk("R7 inverted bounds linear", next_o, 16'h2002);
    endtask

    task automatic t_rev;
        logic [15:0] p = 16'h0400;
        logic [15:0] exp;
        issue(2'd2, 1'b1, p, 16'h0010, 16'h0, 16'h0, 4'd4);
        chk("R8 first reversed step", next_o, 16'h0410);
        p = next_o;
        issue(2'd2, 1'b1, p, 16'h0010, 16'h0, 16'h0, 4'd4);
        chk("R8 reversed carry", next_o, 16'h0408);
        p = next_o;
        for (int k = 0; k < 14; k++) begin
            exp = ref_rev(p, 16'h0010, 4);
            issue(2'd2, 1'b1, p, 16'h0010, 16'h0, 16'h0, 4'd4);
            chk("R8 reversed walk", next_o, exp);
            p = next_o;
        end
        chk("R8 walk returns to base", p, 16'h0400);
        issue(2'd2, 1'b0, 16'hA41F, 16'h0010, 16'h0, 16'h0, 4'd4);
        chk("R8 outer bits and bit0 kept", next_o, ref_rev(16'hA41F, 16'h0010, 4));
        issue(2'd2, 1'b0, 16'h8000, 16'h8000, 16'h0, 16'h0, 4'd15);
        chk("R8 widest span carry", next_o, 16'h4000);
        issue(2'd2, 1'b0, 16'h0400, 16'h0010, 16'h0, 16'h0, 4'd0);
        chk("R9 zero span linear", next_o, 16'h0410);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_pre();
        rst_n = 1'b1;
        t_reset;
        t_linear;
        t_word_addr;
        t_idle_hold;
        t_circ;
        t_rev;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic t_reset_pre;
        chk("R1 reset valid low", {15'd0, valid_o}, 16'd0);
        chk("R1 reset next zero", next_o, 16'h0000);
    endtask

endmodule